// File: doc/BRIEF.md
# Multi-Drive Seek and Recalibrate Sequencer

This block keeps the head position of each drive on a multi-drive disk controller and times positioning commands. Every drive holds a cylinder register and a small state machine with two timed phases. A command passes a short fixed lead phase. For a seek or a recalibrate, the end of that lead phase releases the shared controller busy flag, loads the drive's cylinder register with the target, and starts a travel phase. The travel phase lasts in proportion to the cylinder distance. When travel ends, the drive raises its own attention bit instead of a done flag, so software can command other drives while one arm is still moving.

Data-transfer commands share the same timer. Their lead phase covers seek plus rotational latency. At its end the block emits a one-cycle hand-off pulse to the transfer engine, which is outside this block. The controller then stays busy until that engine reports completion. A status multiplexer reports, for the drive picked by a select input, whether it is seeking, not ready, unsafe (no medium), or parked beyond the last valid cylinder. One time unit is one clock cycle.

Top module: `seek_sequencer`

## Requirements
- R1: After reset the controller is not busy, every attention bit is 0, no hand-off pulse is present and every drive's cylinder reads 0.
- R2: A command is accepted (`cmd_accept` high in the cycle before the edge) only when the controller is free and the addressed drive is inactive. An accepted no-op (code 0), recalibrate (code 3) or seek (code 4) sets busy, and busy falls 2 cycles after the accepting edge.
- R3: A seek moves to `cmd_cyl` and a recalibrate moves to cylinder 0. The drive's cylinder register takes the target at the end of the 2-cycle lead phase and holds it through the travel phase.
- R4: The travel phase lasts max(2, |target - old cylinder| x `seek_per_cyl`) cycles. At its last edge the drive's attention bit rises and busy is left unchanged.
- R5: Accepting any command for a drive clears that drive's attention bit at the accepting edge. A no-op command never raises attention.
- R6: While the selected drive is in either phase of a seek or recalibrate, `sel_seeking` and `sel_not_ready` are both 1. Both fall when travel ends.
- R7: A selected drive whose attach input is 0 shows `sel_unsafe` and `sel_not_ready` and never `sel_seeking`, even while it is positioning.
- R8: An attached, inactive selected drive whose cylinder is 203 or more shows `sel_seek_inc`. Otherwise that output is 0.
- R9: A command is ignored while busy, or while its drive is still active. In that case `cmd_accept` is 0, and the drive's cylinder, status and attention are untouched.
- R10: A transfer command (codes 1, 2, 5, 6, 7) to an attached drive waits max(2, |`cmd_cyl` - cylinder| x `seek_per_cyl` + `rot_time`) cycles. To an unattached drive it waits 2 cycles. `xfer_go` is high for the one cycle after that edge, with `xfer_unit` naming the drive. Busy stays set until `xfer_done`, and the cylinder register does not move.
- R11: Once busy has dropped, another drive can be commanded while an earlier drive is still travelling. Each drive raises its attention on its own schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_go | input | 1 | Command strobe |
| cmd_unit | input | 3 | Drive addressed by the command |
| cmd_func | input | 3 | Command code |
| cmd_cyl | input | 8 | Cylinder field of the disk address |
| sel_unit | input | 3 | Drive whose status is reported |
| drv_attached | input | 8 | Per-drive medium present |
| seek_per_cyl | input | 16 | Travel cycles per cylinder of distance |
| rot_time | input | 16 | Rotational latency cycles added to transfers |
| xfer_done | input | 1 | Transfer engine finished; releases busy |
| cmd_accept | output | 1 | Command is taken at the coming edge |
| busy | output | 1 | Controller busy |
| attn | output | 8 | Per-drive attention bits |
| xfer_go | output | 1 | One-cycle hand-off to the transfer engine |
| xfer_unit | output | 3 | Drive for the hand-off |
| sel_cyl | output | 8 | Cylinder register of the selected drive |
| sel_seeking | output | 1 | Selected drive positioning |
| sel_not_ready | output | 1 | Selected drive not ready |
| sel_unsafe | output | 1 | Selected drive has no medium |
| sel_seek_inc | output | 1 | Selected drive parked past the last cylinder |

## Verification
The bench sweeps seeks and recalibrates across many drives and distances. It includes zero distance, zero per-cylinder time and cylinders above the valid range, and it pins the exact cycle at which busy drops and attention rises. A design that is off by one in either phase, or that loads the cylinder at the wrong time, misses those sample points. The bench also overlaps a long seek on one drive with commands to the same and other drives: a design that kept busy through travel, or that let a command restart a moving drive, fails there. Transfers check the rotation term, the 2-cycle floor for unattached drives and the busy hold until completion, which catches a design that wrongly moves the arm or raises attention on a transfer.

// File: rtl/seekseq_pkg.sv
package seekseq_pkg;

  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_RD     = 3'd1,
    OP_WR     = 3'd2,
    OP_HOME   = 3'd3,
    OP_SEEK   = 3'd4,
    OP_RD_RAW = 3'd5,
    OP_WR_RAW = 3'd6,
    OP_VERIFY = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    JOB_NOP  = 2'd0,
    JOB_POS  = 2'd1,
    JOB_XFER = 2'd2
  } job_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LEAD = 2'd1,
    ST_MOVE = 2'd2
  } dstate_e;

  // absolute cylinder distance
  function automatic int unsigned cyl_gap(input int unsigned a, input int unsigned b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  // gap * per + extra, never below the floor
  function automatic int unsigned span_delay(input int unsigned gap, input int unsigned per,
                                             input int unsigned extra, input int unsigned floor_v);
    int unsigned raw;
    raw = gap * per + extra;
    return (raw < floor_v) ? floor_v : raw;
  endfunction

  function automatic logic is_positioning(input op_e op);
    return (op == OP_SEEK) || (op == OP_HOME);
  endfunction

endpackage

// File: rtl/drive_seek_fsm.sv
module drive_seek_fsm
  import seekseq_pkg::*;
#(
  parameter int          CYLW    = 8,
  parameter int          TW      = 16,
  parameter int          CNTW    = CYLW + TW + 1,
  parameter int unsigned MIN_DLY = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            launch,
  input  op_e             op,
  input  logic [CYLW-1:0] tgt,
  input  logic            attached,
  input  logic [TW-1:0]   spc,
  input  logic [TW-1:0]   rot,
  output logic            active,
  output logic            positioning,
  output logic [CYLW-1:0] cyl,
  output logic            release_o,
  output logic            fire_o,
  output logic            attn
);

  dstate_e         st;
  job_e            job;
  logic [CNTW-1:0] cnt;
  logic [CYLW-1:0] dest;

  // named events for the assertions and the top
  logic            phase_end;
  logic            lead_end;
  logic            move_end;
  logic [CNTW-1:0] lead_dly;
  logic [CNTW-1:0] move_dly;
  job_e            new_job;

  assign phase_end = (cnt == CNTW'(1));
  assign lead_end  = (st == ST_LEAD) && phase_end;
  assign move_end  = (st == ST_MOVE) && phase_end;

  always_comb begin
    if (op == OP_NOP)            new_job = JOB_NOP;
    else if (is_positioning(op)) new_job = JOB_POS;
    else                         new_job = JOB_XFER;
  end

  always_comb begin
    if (new_job != JOB_XFER || !attached)
      lead_dly = CNTW'(MIN_DLY);
    else
      lead_dly = CNTW'(span_delay(cyl_gap(32'(tgt), 32'(cyl)), 32'(spc), 32'(rot), MIN_DLY));
    move_dly = CNTW'(span_delay(cyl_gap(32'(dest), 32'(cyl)), 32'(spc), 32'd0, MIN_DLY));
  end

  assign active      = (st != ST_IDLE);
  assign positioning = active && (job == JOB_POS);
  assign release_o   = lead_end && (job != JOB_XFER);
  assign fire_o      = lead_end && (job == JOB_XFER);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      job  <= JOB_NOP;
      cnt  <= '0;
      cyl  <= '0;
      dest <= '0;
      attn <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (launch) begin
            st   <= ST_LEAD;
            job  <= new_job;
            cnt  <= lead_dly;
            attn <= 1'b0;
            dest <= (op == OP_SEEK) ? tgt : '0;
          end
        end
        ST_LEAD: begin
          if (phase_end) begin
            if (job == JOB_POS) begin
              cyl <= dest;
              cnt <= move_dly;
              st  <= ST_MOVE;
            end else begin
              st <= ST_IDLE;
            end
          end else begin
            cnt <= cnt - CNTW'(1);
          end
        end
        ST_MOVE: begin
          if (phase_end) begin
            attn <= 1'b1;
            st   <= ST_IDLE;
          end else begin
            cnt <= cnt - CNTW'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R4: travel end raises attention on the next cycle
  p_attn_on_finish_r4: assert property (@(posedge clk) disable iff (!rst_n)
    move_end |=> attn);

  // R3: cylinder register holds still through the travel phase
  p_cyl_still_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MOVE) |=> $stable(cyl));

  // R9: an accepted launch always starts the lead phase
  p_launch_starts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (st == ST_LEAD));

  // R5: a launch clears attention
  p_launch_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !attn);

endmodule

// File: rtl/unit_status_mux.sv
module unit_status_mux #(
  parameter int          NDRV = 8,
  parameter int          UW   = 3,
  parameter int          CYLW = 8,
  parameter int unsigned NCYL = 203
) (
  input  logic [UW-1:0]              sel,
  input  logic [NDRV-1:0]            attached,
  input  logic [NDRV-1:0]            act,
  input  logic [NDRV-1:0]            pos,
  input  logic [NDRV-1:0][CYLW-1:0]  cyls,
  output logic [CYLW-1:0]            sel_cyl,
  output logic                       sel_seeking,
  output logic                       sel_not_ready,
  output logic                       sel_unsafe,
  output logic                       sel_seek_inc
);

  logic a, ac, p;

  assign a       = attached[sel];
  assign ac      = act[sel];
  assign p       = pos[sel];
  assign sel_cyl = cyls[sel];

  always_comb begin
    sel_unsafe    = 1'b0;
    sel_not_ready = 1'b0;
    sel_seeking   = 1'b0;
    sel_seek_inc  = 1'b0;
    if (!a) begin
      sel_unsafe    = 1'b1;
      sel_not_ready = 1'b1;
    end else if (ac) begin
      if (p) begin
        sel_seeking   = 1'b1;
        sel_not_ready = 1'b1;
      end
    end else if (32'(sel_cyl) >= NCYL) begin
      sel_seek_inc = 1'b1;
    end
  end

endmodule

// File: rtl/seek_sequencer.sv
module seek_sequencer
  import seekseq_pkg::*;
#(
  parameter int          NDRV    = 8,
  parameter int          CYLW    = 8,
  parameter int          TW      = 16,
  parameter int unsigned NCYL    = 203,
  parameter int unsigned MIN_DLY = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cmd_go,
  input  logic [$clog2(NDRV)-1:0]      cmd_unit,
  input  logic [2:0]                   cmd_func,
  input  logic [CYLW-1:0]              cmd_cyl,
  input  logic [$clog2(NDRV)-1:0]      sel_unit,
  input  logic [NDRV-1:0]              drv_attached,
  input  logic [TW-1:0]                seek_per_cyl,
  input  logic [TW-1:0]                rot_time,
  input  logic                         xfer_done,
  output logic                         cmd_accept,
  output logic                         busy,
  output logic [NDRV-1:0]              attn,
  output logic                         xfer_go,
  output logic [$clog2(NDRV)-1:0]      xfer_unit,
  output logic [CYLW-1:0]              sel_cyl,
  output logic                         sel_seeking,
  output logic                         sel_not_ready,
  output logic                         sel_unsafe,
  output logic                         sel_seek_inc
);

  localparam int UW   = $clog2(NDRV);
  localparam int CNTW = CYLW + TW + 1;

  logic [NDRV-1:0]           act_vec;
  logic [NDRV-1:0]           pos_vec;
  logic [NDRV-1:0]           rel_vec;
  logic [NDRV-1:0]           fire_vec;
  logic [NDRV-1:0][CYLW-1:0] cyl_vec;
  logic [UW-1:0]             fire_idx;
  op_e                       op;

  assign op         = op_e'(cmd_func);
  assign cmd_accept = cmd_go && !busy && !act_vec[cmd_unit];

  for (genvar g = 0; g < NDRV; g++) begin : g_drv
    drive_seek_fsm #(
      .CYLW(CYLW), .TW(TW), .CNTW(CNTW), .MIN_DLY(MIN_DLY)
    ) u_drv (
      .clk         (clk),
      .rst_n       (rst_n),
      .launch      (cmd_accept && (cmd_unit == UW'(g))),
      .op          (op),
      .tgt         (cmd_cyl),
      .attached    (drv_attached[g]),
      .spc         (seek_per_cyl),
      .rot         (rot_time),
      .active      (act_vec[g]),
      .positioning (pos_vec[g]),
      .cyl         (cyl_vec[g]),
      .release_o   (rel_vec[g]),
      .fire_o      (fire_vec[g]),
      .attn        (attn[g])
    );
  end

  always_comb begin
    fire_idx = '0;
    for (int i = 0; i < NDRV; i++)
      if (fire_vec[i]) fire_idx = UW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      xfer_go   <= 1'b0;
      xfer_unit <= '0;
    end else begin
      if (cmd_accept)                   busy <= 1'b1;
      else if ((|rel_vec) || xfer_done) busy <= 1'b0;
      xfer_go <= |fire_vec;
      if (|fire_vec) xfer_unit <= fire_idx;
    end
  end

  unit_status_mux #(
    .NDRV(NDRV), .UW(UW), .CYLW(CYLW), .NCYL(NCYL)
  ) u_status (
    .sel           (sel_unit),
    .attached      (drv_attached),
    .act           (act_vec),
    .pos           (pos_vec),
    .cyls          (cyl_vec),
    .sel_cyl       (sel_cyl),
    .sel_seeking   (sel_seeking),
    .sel_not_ready (sel_not_ready),
    .sel_unsafe    (sel_unsafe),
    .sel_seek_inc  (sel_seek_inc)
  );

  // R2: busy only drops on a lead-phase release or transfer completion
  p_busy_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past((|rel_vec) || xfer_done));

  // R10: a transfer hand-off only occurs while the controller is busy
  p_fire_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|fire_vec) |-> busy);

  // R11: at most one drive finishes a lead phase per cycle
  p_rel_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rel_vec | fire_vec));

  // R6: seeking status implies not-ready
  p_seek_nr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sel_seeking |-> sel_not_ready);

endmodule

// File: tb/tb_seek_sequencer.sv
`timescale 1ns/1ps
module tb_seek_sequencer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_go = 1'b0;
  logic [2:0]  cmd_unit = '0;
  logic [2:0]  cmd_func = '0;
  logic [7:0]  cmd_cyl = '0;
  logic [2:0]  sel_unit = '0;
  logic [7:0]  drv_attached = 8'b1111_0111;
  logic [15:0] seek_per_cyl = 16'd10;
  logic [15:0] rot_time = 16'd10;
  logic        xfer_done = 1'b0;
  logic        cmd_accept, busy, xfer_go;
  logic [7:0]  attn;
  logic [2:0]  xfer_unit;
  logic [7:0]  sel_cyl;
  logic        sel_seeking, sel_not_ready, sel_unsafe, sel_seek_inc;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int mcyl [8];
  bit finished = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  seek_sequencer dut (
    .clk(clk), .rst_n(rst_n), .cmd_go(cmd_go), .cmd_unit(cmd_unit),
    .cmd_func(cmd_func), .cmd_cyl(cmd_cyl), .sel_unit(sel_unit),
    .drv_attached(drv_attached), .seek_per_cyl(seek_per_cyl),
    .rot_time(rot_time), .xfer_done(xfer_done), .cmd_accept(cmd_accept),
    .busy(busy), .attn(attn), .xfer_go(xfer_go), .xfer_unit(xfer_unit),
    .sel_cyl(sel_cyl), .sel_seeking(sel_seeking),
    .sel_not_ready(sel_not_ready), .sel_unsafe(sel_unsafe),
    .sel_seek_inc(sel_seek_inc)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d (edge %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int travel(input int from, input int to, input int per);
    int d;
    d = (from > to ? from - to : to - from) * per;
    return (d < 2) ? 2 : d;
  endfunction

  task automatic at_edge(input int e);
    while (cyc < e) @(negedge clk);
  endtask

  task automatic look(input int u);
    sel_unit = 3'(u);
    #1;
  endtask

  task automatic issue(input int u, input int f, input int c, output bit acc, output int k);
    @(negedge clk);
    cmd_unit = 3'(u); cmd_func = 3'(f); cmd_cyl = 8'(c); cmd_go = 1'b1;
    #1 acc = cmd_accept;
    @(posedge clk);
    @(negedge clk);
    cmd_go = 1'b0;
    k = cyc;
    #1;
  endtask

  // full timing check of one seek (f=4) or recalibrate (f=3) on an attached drive
  task automatic do_seek(input int u, input int f, input int c);
    bit acc; int k; int tgt; int d2;
    tgt = (f == 4) ? c : 0;
    d2  = travel(mcyl[u], tgt, int'(seek_per_cyl));
    issue(u, f, c, acc, k);
    look(u);
    chk("R2", "accept", int'(acc), 1);
    chk("R2", "busy after accept", int'(busy), 1);
    chk("R5", "attn cleared on accept", int'(attn[u]), 0);
    chk("R6", "seeking in lead", int'(sel_seeking), 1);
    chk("R6", "not ready in lead", int'(sel_not_ready), 1);
    at_edge(k + 1); #1;
    chk("R2", "busy mid lead", int'(busy), 1);
    chk("R3", "cyl before lead end", int'(sel_cyl), mcyl[u]);
    at_edge(k + 2); #1;
    chk("R2", "busy released", int'(busy), 0);
    chk("R3", "cyl loaded", int'(sel_cyl), tgt);
    chk("R6", "seeking in travel", int'(sel_seeking), 1);
    at_edge(k + 1 + d2); #1;
    chk("R4", "attn before end", int'(attn[u]), 0);
    chk("R6", "seeking before end", int'(sel_seeking), 1);
    at_edge(k + 2 + d2); #1;
    chk("R4", "attn at end", int'(attn[u]), 1);
    chk("R4", "busy unchanged at end", int'(busy), 0);
    chk("R6", "seeking off", int'(sel_seeking), 0);
    chk("R6", "ready again", int'(sel_not_ready), 0);
    mcyl[u] = tgt;
  endtask

  // transfer check with computed lead delay
  task automatic do_xfer(input int u, input int f, input int c, input int dly);
    bit acc; int k;
    issue(u, f, c, acc, k);
    look(u);
    chk("R10", "xfer accept", int'(acc), 1);
    chk("R10", "xfer busy", int'(busy), 1);
    if (drv_attached[u]) chk("R10", "xfer not seeking", int'(sel_seeking), 0);
    at_edge(k + dly - 1); #1;
    chk("R10", "hand-off early", int'(xfer_go), 0);
    at_edge(k + dly); #1;
    chk("R10", "hand-off", int'(xfer_go), 1);
    chk("R10", "hand-off unit", int'(xfer_unit), u);
    chk("R10", "busy held", int'(busy), 1);
    at_edge(k + dly + 1); #1;
    chk("R10", "hand-off single", int'(xfer_go), 0);
    chk("R10", "busy still held", int'(busy), 1);
    chk("R10", "cyl unmoved", int'(sel_cyl), mcyl[u]);
    chk("R10", "no attention", int'(attn[u]), 0);
    @(negedge clk); xfer_done = 1'b1;
    @(negedge clk); xfer_done = 1'b0; #1;
    chk("R10", "busy after done", int'(busy), 0);
  endtask

  initial begin
    bit acc; int k0, k1, kx;
    for (int i = 0; i < 8; i++) mcyl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R1
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "attn", int'(attn), 0);
    chk("R1", "xfer_go", int'(xfer_go), 0);
    for (int u = 0; u < 8; u++) begin
      look(u);
      chk("R1", "cylinder", int'(sel_cyl), 0);
    end

    // sweep of seeks and recalibrates
    seek_per_cyl = 16'd3;
    for (int i = 0; i < 14; i++) begin
      int u;
      u = (i * 5) % 8;
      if (u == 3) u = 0;
      if (i % 4 == 3) do_seek(u, 3, 99);
      else            do_seek(u, 4, (i * 53 + 7) % 256);
    end
    do_seek(1, 4, mcyl[1]);        // zero distance -> floor of 2
    seek_per_cyl = 16'd0;
    do_seek(2, 4, 180);            // zero per-cylinder time -> floor of 2
    seek_per_cyl = 16'd1;

    // R8: beyond the last cylinder
    do_seek(0, 4, 230);
    look(0);
    chk("R8", "seek incomplete", int'(sel_seek_inc), 1);
    do_seek(0, 4, 203);
    chk("R8", "boundary 203", int'(sel_seek_inc), 1);
    do_seek(0, 4, 202);
    chk("R8", "boundary 202", int'(sel_seek_inc), 0);
    do_seek(0, 4, 5);

    // R5: no-op clears attention and raises none
    issue(0, 0, 77, acc, kx);
    look(0);
    chk("R5", "nop accepted", int'(acc), 1);
    chk("R5", "attn cleared", int'(attn[0]), 0);
    at_edge(kx + 1); #1;
    chk("R2", "nop busy", int'(busy), 1);
    at_edge(kx + 2); #1;
    chk("R2", "nop release", int'(busy), 0);
    at_edge(kx + 6); #1;
    chk("R5", "nop no attn", int'(attn[0]), 0);
    chk("R5", "nop cyl", int'(sel_cyl), 5);

    // R9 / R11: overlap
    seek_per_cyl = 16'd4;
    issue(0, 4, 105, acc, k0);
    chk("R9", "first seek accepted", int'(acc), 1);
    issue(1, 4, 9, acc, kx);
    chk("R9", "ignored while busy", int'(acc), 0);
    look(1);
    chk("R9", "other drive idle", int'(sel_seeking), 0);
    chk("R9", "other drive cyl", int'(sel_cyl), mcyl[1]);
    at_edge(k0 + 3);
    issue(0, 4, 50, acc, kx);
    chk("R9", "ignored while drive active", int'(acc), 0);
    issue(1, 4, mcyl[1] + 10, acc, k1);
    chk("R11", "other drive accepted", int'(acc), 1);
    at_edge(k1 + 41); #1;
    chk("R11", "drive1 attn early", int'(attn[1]), 0);
    at_edge(k1 + 42); #1;
    chk("R11", "drive1 attn", int'(attn[1]), 1);
    chk("R11", "drive0 still moving", int'(attn[0]), 0);
    mcyl[1] = mcyl[1] + 10;
    at_edge(k0 + 401); #1;
    chk("R9", "drive0 attn not restarted early", int'(attn[0]), 0);
    at_edge(k0 + 402); #1;
    chk("R9", "drive0 attn on original schedule", int'(attn[0]), 1);
    look(0);
    chk("R9", "drive0 kept first target", int'(sel_cyl), 105);
    mcyl[0] = 105;

    // R7: unattached drive
    look(3);
    chk("R7", "unsafe", int'(sel_unsafe), 1);
    chk("R7", "not ready", int'(sel_not_ready), 1);
    issue(3, 4, 40, acc, kx);
    look(3);
    chk("R7", "accepted", int'(acc), 1);
    chk("R7", "no seeking shown", int'(sel_seeking), 0);
    chk("R7", "still unsafe", int'(sel_unsafe), 1);
    chk("R7", "still not ready", int'(sel_not_ready), 1);
    at_edge(kx + 2 + travel(0, 40, 4)); #1;
    chk("R3", "unattached cyl", int'(sel_cyl), 40);
    chk("R4", "unattached attn", int'(attn[3]), 1);
    mcyl[3] = 40;
    look(0);
    chk("R7", "attached not unsafe", int'(sel_unsafe), 0);

    // R10: transfers
    seek_per_cyl = 16'd2;
    rot_time = 16'd5;
    do_seek(2, 4, 50);
    do_xfer(2, 1, 60, 25);
    rot_time = 16'd0;
    do_xfer(2, 2, 50, 2);
    rot_time = 16'd9;
    do_xfer(2, 7, 50, 9);
    do_xfer(4, 5, mcyl[4] + 3, 15);
    do_xfer(3, 1, 200, 2);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule